// File: doc/BRIEF.md
# Framebuffer Run Copy and Fill Engine

This engine moves or paints short horizontal runs of pixels inside an 8-bit framebuffer. Software drives it through a 32-bit register write port. A command needs two writes. The first write parks a colour or value word in a holding register. The second write starts the run. The pixel index of the run's first destination pixel comes from the bus address of that second write. The source index and the run length come from its data word. One source value is reserved. It turns the run into a fill with the held colour instead of a copy.

Every pixel plane is reached through its own simple dual-port synchronous RAM master, with separate read and write channels. Read data arrives one clock after the read request. The engine always updates the 8-bit plane. When the depth input selects deep mode, it also updates a 32-bit-per-pixel plane. A raw command in deep mode also updates a 32-bit control plane. The run is issued in ascending pixel order, one pixel per clock. A busy flag covers the run, and a wait signal holds off any further command until the run is over.

Top module: `pix_run_engine`

## Requirements
- R1: A full-width write with bus address bit 2 clear only stores the data word as the held value; busy stays low and no plane is written.
- R2: A full-width write with address bit 2 set starts a run. The destination index is address bits 22:3. The length is data bits 28:24 plus one (1 to 32). The run writes the 8-bit plane at destination, destination+1, and so on up to the last pixel of the run, one pixel per clock.
- R3: A source field (data bits 23:0) of all ones selects fill mode: every pixel of the run in the 8-bit plane receives bits 7:0 of the held value.
- R4: Any other source field selects copy mode: pixel k of the run takes the 8-bit plane value at source index bits 19:0 plus k.
- R5: With depth input high, fill also writes the 32-bit plane with bits 23:0 of the held value and a zero top byte, and copy also copies the matching 32-bit-plane words; with depth input low the 32-bit plane is never written.
- R6: A command whose address bit 23 is set (raw) in deep mode gives the control plane the same treatment as the 32-bit plane, copying control words from control words; otherwise the control plane is never written.
- R7: Reads return zero without wait; writes whose byte enables are not all set are ignored.
- R8: Busy is high from the clock after a command is accepted for length+1 cycles. A command write during busy sees wait high and is taken once busy drops. A holding write during busy is taken at once without wait, and it does not change the colour of the run in progress.
- R9: When source and destination overlap, the result equals a sequential copy in ascending pixel order (destination = source+1 replicates the first source pixel).
- R10: During reset busy is low and no plane read or write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth24_i | input | 1 | Deep mode: also update the 32-bit plane |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 24 | Byte address within the engine window |
| reg_be_i | input | 4 | Byte enables; only all ones is accepted |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, always zero |
| reg_wait_o | output | 1 | Holds the current access |
| busy_o | output | 1 | A run is in progress |
| p8_rd_o | output | 1 | 8-bit plane read request |
| p8_raddr_o | output | 20 | 8-bit plane read index |
| p8_rdata_i | input | 8 | 8-bit plane read data, one clock later |
| p8_wr_o | output | 1 | 8-bit plane write request |
| p8_waddr_o | output | 20 | 8-bit plane write index |
| p8_wdata_o | output | 8 | 8-bit plane write data |
| p32_rd_o | output | 1 | 32-bit plane read request |
| p32_raddr_o | output | 20 | 32-bit plane read index |
| p32_rdata_i | input | 32 | 32-bit plane read data |
| p32_wr_o | output | 1 | 32-bit plane write request |
| p32_waddr_o | output | 20 | 32-bit plane write index |
| p32_wdata_o | output | 32 | 32-bit plane write data |
| pc_rd_o | output | 1 | Control plane read request |
| pc_raddr_o | output | 20 | Control plane read index |
| pc_rdata_i | input | 32 | Control plane read data |
| pc_wr_o | output | 1 | Control plane write request |
| pc_waddr_o | output | 20 | Control plane write index |
| pc_wdata_o | output | 32 | Control plane write data |

## Verification
A wrong run counter or a wrong length capture shows up at once as a wrong number of busy cycles or plane writes for that command. It also shows as corrupted pixels next to the run, which a comparison of the planes catches as soon as the run ends. A wrong capture of the held colour or of the plane mask shows as wrong pixel values, or as unexpected writes to the deep or control planes, in the same run. A missing read-after-write forward only shows under a copy whose destination is the source plus one. From its second pixel on, that run then stops replicating the first value, so a directed overlap test exposes the fault within that run.

// File: rtl/pix_run_pkg.sv
package pix_run_pkg;

  typedef enum logic [1:0] {
    PL_BYTE = 2'd0,
    PL_DEEP = 2'd1,
    PL_CTRL = 2'd2
  } plane_e;

  localparam int unsigned NPLANE = 3;

  function automatic logic [NPLANE-1:0] plane_mask(input logic deep, input logic raw);
    logic [NPLANE-1:0] m;
    m          = '0;
    m[PL_BYTE] = 1'b1;
    m[PL_DEEP] = deep;
    m[PL_CTRL] = deep & raw;
    return m;
  endfunction

endpackage

// File: rtl/pix_cmd_port.sv
module pix_cmd_port #(
  parameter  int unsigned PIX_AW = 20,
  parameter  int unsigned SRC_W  = 24,
  parameter  int unsigned LEN_W  = 5,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned BUS_AW = PIX_AW + 4,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o,
  output logic              start_o,
  output logic [PIX_AW-1:0] dst_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic              raw_o,
  output logic [DATA_W-1:0] latch_o
);
  localparam int unsigned CMD_BIT = 2;
  localparam int unsigned DST_LSB = 3;
  localparam int unsigned RAW_BIT = PIX_AW + 3;

  logic wr_ok, is_cmd;
  logic [DATA_W-1:0] latch_q;

  assign wr_ok    = req_i & we_i & (&be_i);
  assign is_cmd   = wr_ok & addr_i[CMD_BIT];
  assign wait_o   = is_cmd & busy_i;
  assign start_o  = is_cmd & ~busy_i;
  assign dst_o    = addr_i[DST_LSB +: PIX_AW];
  assign raw_o    = addr_i[RAW_BIT];
  assign src_o    = wdata_i[SRC_W-1:0];
  assign len_m1_o = wdata_i[SRC_W +: LEN_W];
  assign rdata_o  = '0;
  assign latch_o  = latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else if (wr_ok && !addr_i[CMD_BIT]) latch_q <= wdata_i;
  end

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:SRC_W+LEN_W]};

  // R8: a command is never launched on top of a running one
  a_r8_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);

endmodule

// File: rtl/pix_run_seq.sv
module pix_run_seq #(
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NPL    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIX_AW-1:0] dst_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [DATA_W-1:0] latch_i,
  input  logic [NPL-1:0]    pmask_i,
  output logic              busy_o,
  output logic              fill_o,
  output logic [DATA_W-1:0] colour_o,
  output logic [NPL-1:0]    pmask_o,
  output logic              rd_vld_o,
  output logic [PIX_AW-1:0] rd_addr_o,
  output logic              wr_vld_o,
  output logic [PIX_AW-1:0] wr_addr_o
);
  localparam logic [SRC_W-1:0] FILL_KEY = {SRC_W{1'b1}};

  logic              run_q, s1_vld_q, fill_q;
  logic [LEN_W-1:0]  idx_q, len_q, off_q;
  logic [PIX_AW-1:0] dst_q, src_q;
  logic [DATA_W-1:0] colour_q;
  logic [NPL-1:0]    pmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      s1_vld_q <= 1'b0;
      fill_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      off_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      colour_q <= '0;
      pmask_q  <= '0;
    end else begin
      s1_vld_q <= run_q;
      if (run_q) off_q <= idx_q;
      if (start_i) begin
        run_q    <= 1'b1;
        idx_q    <= '0;
        len_q    <= len_m1_i;
        dst_q    <= dst_i;
        src_q    <= src_i[PIX_AW-1:0];
        fill_q   <= (src_i == FILL_KEY);
        colour_q <= latch_i;
        pmask_q  <= pmask_i;
      end else if (run_q) begin
        if (idx_q == len_q) run_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o    = run_q | s1_vld_q;
  assign fill_o    = fill_q;
  assign colour_o  = colour_q;
  assign pmask_o   = pmask_q;
  assign rd_vld_o  = run_q & ~fill_q;
  assign rd_addr_o = src_q + PIX_AW'(idx_q);
  assign wr_vld_o  = s1_vld_q;
  assign wr_addr_o = dst_q + PIX_AW'(off_q);

  logic [LEN_W:0] wcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcnt_q <= '0;
    else if (start_i) wcnt_q <= '0;
    else if (wr_vld_o) wcnt_q <= wcnt_q + 1'b1;
  end

  // R2: never more writes than the run length
  a_r2_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> wcnt_q <= {1'b0, len_q});
  // R2: consecutive writes step up by one pixel
  a_r2_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_o && $past(wr_vld_o)) |-> wr_addr_o == $past(wr_addr_o) + 1'b1);

endmodule

// File: rtl/pix_plane_lane.sv
module pix_plane_lane #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fill_i,
  input  logic [DW-1:0] fill_val_i,
  input  logic          rd_vld_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_vld_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          ram_rd_o,
  output logic [AW-1:0] ram_raddr_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_wr_o,
  output logic [AW-1:0] ram_waddr_o,
  output logic [DW-1:0] ram_wdata_o
);
  logic          hit_q;
  logic [DW-1:0] fwd_q;

  assign ram_rd_o    = en_i & rd_vld_i;
  assign ram_raddr_o = rd_addr_i;
  assign ram_wr_o    = en_i & wr_vld_i;
  assign ram_waddr_o = wr_addr_i;
  // same-cycle read of the address being written returns old data: forward
  assign ram_wdata_o = fill_i ? fill_val_i : (hit_q ? fwd_q : ram_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      fwd_q <= '0;
    end else begin
      hit_q <= ram_rd_o & ram_wr_o & (ram_raddr_o == ram_waddr_o);
      fwd_q <= ram_wdata_o;
    end
  end

  // R4: every copy write is backed by a read one clock earlier
  a_r4_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_wr_o && !fill_i) |-> $past(ram_rd_o));

endmodule

// File: rtl/pix_run_engine.sv
module pix_run_engine #(
  parameter  int unsigned PIX_AW  = 20,
  parameter  int unsigned SRC_W   = 24,
  parameter  int unsigned LEN_W   = 5,
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned PIX_W   = 8,
  parameter  int unsigned COLOR_W = 24,
  localparam int unsigned BUS_AW  = PIX_AW + 4,
  localparam int unsigned BE_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              depth24_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [BUS_AW-1:0] reg_addr_i,
  input  logic [BE_W-1:0]   reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_wait_o,
  output logic              busy_o,
  output logic              p8_rd_o,
  output logic [PIX_AW-1:0] p8_raddr_o,
  input  logic [PIX_W-1:0]  p8_rdata_i,
  output logic              p8_wr_o,
  output logic [PIX_AW-1:0] p8_waddr_o,
  output logic [PIX_W-1:0]  p8_wdata_o,
  output logic              p32_rd_o,
  output logic [PIX_AW-1:0] p32_raddr_o,
  input  logic [DATA_W-1:0] p32_rdata_i,
  output logic              p32_wr_o,
  output logic [PIX_AW-1:0] p32_waddr_o,
  output logic [DATA_W-1:0] p32_wdata_o,
  output logic              pc_rd_o,
  output logic [PIX_AW-1:0] pc_raddr_o,
  input  logic [DATA_W-1:0] pc_rdata_i,
  output logic              pc_wr_o,
  output logic [PIX_AW-1:0] pc_waddr_o,
  output logic [DATA_W-1:0] pc_wdata_o
);
  import pix_run_pkg::*;

  localparam int unsigned NWIDE = NPLANE - 1;

  logic              start, raw, fill, rd_vld, wr_vld;
  logic [PIX_AW-1:0] dst, rd_addr, wr_addr;
  logic [SRC_W-1:0]  src;
  logic [LEN_W-1:0]  len_m1;
  logic [DATA_W-1:0] latch, colour;
  logic [NPLANE-1:0] pmask;
  logic [DATA_W-1:0] wide_fill;

  pix_cmd_port #(.PIX_AW(PIX_AW), .SRC_W(SRC_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_port (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .be_i(reg_be_i),
    .wdata_i(reg_wdata_i), .busy_i(busy_o), .rdata_o(reg_rdata_o), .wait_o(reg_wait_o),
    .start_o(start), .dst_o(dst), .src_o(src), .len_m1_o(len_m1), .raw_o(raw),
    .latch_o(latch)
  );

  pix_run_seq #(.PIX_AW(PIX_AW), .SRC_W(SRC_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
                .NPL(NPLANE)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .dst_i(dst), .src_i(src), .len_m1_i(len_m1), .latch_i(latch),
    .pmask_i(plane_mask(depth24_i, raw)),
    .busy_o(busy_o), .fill_o(fill), .colour_o(colour), .pmask_o(pmask),
    .rd_vld_o(rd_vld), .rd_addr_o(rd_addr), .wr_vld_o(wr_vld), .wr_addr_o(wr_addr)
  );

  pix_plane_lane #(.AW(PIX_AW), .DW(PIX_W)) u_byte (
    .clk_i, .rst_ni,
    .en_i(pmask[PL_BYTE]), .fill_i(fill), .fill_val_i(colour[PIX_W-1:0]),
    .rd_vld_i(rd_vld), .rd_addr_i(rd_addr), .wr_vld_i(wr_vld), .wr_addr_i(wr_addr),
    .ram_rd_o(p8_rd_o), .ram_raddr_o(p8_raddr_o), .ram_rdata_i(p8_rdata_i),
    .ram_wr_o(p8_wr_o), .ram_waddr_o(p8_waddr_o), .ram_wdata_o(p8_wdata_o)
  );

  assign wide_fill = {{(DATA_W-COLOR_W){1'b0}}, colour[COLOR_W-1:0]};

  logic [NWIDE-1:0]  w_rd, w_wr;
  logic [PIX_AW-1:0] w_raddr [NWIDE];
  logic [PIX_AW-1:0] w_waddr [NWIDE];
  logic [DATA_W-1:0] w_rdata [NWIDE];
  logic [DATA_W-1:0] w_wdata [NWIDE];

  assign w_rdata[0] = p32_rdata_i;
  assign w_rdata[1] = pc_rdata_i;

  for (genvar g = 0; g < NWIDE; g++) begin : g_wide
    pix_plane_lane #(.AW(PIX_AW), .DW(DATA_W)) u_lane (
      .clk_i, .rst_ni,
      .en_i(pmask[g+1]), .fill_i(fill), .fill_val_i(wide_fill),
      .rd_vld_i(rd_vld), .rd_addr_i(rd_addr), .wr_vld_i(wr_vld), .wr_addr_i(wr_addr),
      .ram_rd_o(w_rd[g]), .ram_raddr_o(w_raddr[g]), .ram_rdata_i(w_rdata[g]),
      .ram_wr_o(w_wr[g]), .ram_waddr_o(w_waddr[g]), .ram_wdata_o(w_wdata[g])
    );
  end

  assign p32_rd_o    = w_rd[0];
  assign p32_raddr_o = w_raddr[0];
  assign p32_wr_o    = w_wr[0];
  assign p32_waddr_o = w_waddr[0];
  assign p32_wdata_o = w_wdata[0];
  assign pc_rd_o     = w_rd[1];
  assign pc_raddr_o  = w_raddr[1];
  assign pc_wr_o     = w_wr[1];
  assign pc_waddr_o  = w_waddr[1];
  assign pc_wdata_o  = w_wdata[1];

  // R1: a holding write while idle launches nothing
  a_r1_latch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && !reg_addr_i[2] && !busy_o) |=> !busy_o);
  // R7: partial-width command is dropped
  a_r7_partial_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_addr_i[2] && !(&reg_be_i) && !busy_o) |=> !busy_o);
  // R5: deep plane only moves together with the byte plane
  a_r5_deep_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p32_wr_o |-> (p8_wr_o && p32_waddr_o == p8_waddr_o));
  // R6: control plane only moves together with the deep plane
  a_r6_ctrl_with_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |-> (p32_wr_o && pc_waddr_o == p32_waddr_o));
  // R8: wait only while a run is active
  a_r8_wait_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wait_o |-> busy_o);

endmodule

// File: tb/sim_pix_run_engine.sv
`timescale 1ns/1ps
module sim_pix_run_engine;
  localparam int MD = 4096;
  localparam logic [23:0] FILL = 24'hFFFFFF;

  logic clk = 1'b0, rst_ni = 1'b0, depth24 = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic wait_o, busy;
  logic p8_rd, p8_wr, p32_rd, p32_wr, pc_rd, pc_wr;
  logic [19:0] p8_ra, p8_wa, p32_ra, p32_wa, pc_ra, pc_wa;
  logic [7:0]  p8_rdata = '0, p8_wd;
  logic [31:0] p32_rdata = '0, pc_rdata = '0, p32_wd, pc_wd;

  always #4 clk = ~clk;

  pix_run_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .depth24_i(depth24),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_wait_o(wait_o), .busy_o(busy),
    .p8_rd_o(p8_rd), .p8_raddr_o(p8_ra), .p8_rdata_i(p8_rdata),
    .p8_wr_o(p8_wr), .p8_waddr_o(p8_wa), .p8_wdata_o(p8_wd),
    .p32_rd_o(p32_rd), .p32_raddr_o(p32_ra), .p32_rdata_i(p32_rdata),
    .p32_wr_o(p32_wr), .p32_waddr_o(p32_wa), .p32_wdata_o(p32_wd),
    .pc_rd_o(pc_rd), .pc_raddr_o(pc_ra), .pc_rdata_i(pc_rdata),
    .pc_wr_o(pc_wr), .pc_waddr_o(pc_wa), .pc_wdata_o(pc_wd)
  );

  logic [7:0]  m8 [MD];
  logic [31:0] m32[MD];
  logic [31:0] mc [MD];
  logic [7:0]  r8 [MD];
  logic [31:0] r32[MD];
  logic [31:0] rc [MD];
  logic do_init = 1'b1;

  function automatic logic [7:0]  i8 (int i); return 8'(i * 13 + 5); endfunction
  function automatic logic [31:0] i32(int i); return 32'(i) * 32'h01030507 ^ 32'h5a5a0000; endfunction
  function automatic logic [31:0] ic (int i); return ~(32'(i) * 32'h00010003); endfunction

  // synchronous dual-port RAM models, read returns old data on collision
  always @(posedge clk) begin
    if (do_init) begin
      for (int i = 0; i < MD; i++) begin
        m8[i] <= i8(i); m32[i] <= i32(i); mc[i] <= ic(i);
      end
    end else begin
      if (p8_rd)  p8_rdata  <= m8[p8_ra[11:0]];
      if (p32_rd) p32_rdata <= m32[p32_ra[11:0]];
      if (pc_rd)  pc_rdata  <= mc[pc_ra[11:0]];
      if (p8_wr)  m8[p8_wa[11:0]]   <= p8_wd;
      if (p32_wr) m32[p32_wa[11:0]] <= p32_wd;
      if (pc_wr)  mc[pc_wa[11:0]]   <= pc_wd;
    end
  end

  int c8 = 0, c32 = 0, cc = 0, cb = 0, crd = 0;
  always @(negedge clk) begin
    if (p8_wr)  c8++;
    if (p32_wr) c32++;
    if (pc_wr)  cc++;
    if (busy)   cb++;
    if (p8_rd || p32_rd || pc_rd) crd++;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(logic [23:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    #1;
    while (wait_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [23:0] cmd_addr(int dst, bit raw);
    return {raw, 20'(dst), 3'b100};
  endfunction
  function automatic logic [31:0] cmd_data(logic [23:0] src, int len);
    return {3'b000, 5'(len - 1), src};
  endfunction

  task automatic ref_apply(int dst, logic [23:0] src, int len, logic [31:0] col, bit dp, bit raw);
    for (int k = 0; k < len; k++) begin
      if (src == FILL) begin
        r8[dst+k] = col[7:0];
        if (dp) r32[dst+k] = {8'h00, col[23:0]};
        if (dp && raw) rc[dst+k] = {8'h00, col[23:0]};
      end else begin
        r8[dst+k] = r8[int'(src[19:0])+k];
        if (dp) r32[dst+k] = r32[int'(src[19:0])+k];
        if (dp && raw) rc[dst+k] = rc[int'(src[19:0])+k];
      end
    end
  endtask

  task automatic cmp_planes(string rq);
    int e8 = 0, e32 = 0, ec = 0;
    for (int i = 0; i < MD; i++) begin
      if (m8[i] !== r8[i]) e8++;
      if (m32[i] !== r32[i]) e32++;
      if (mc[i] !== rc[i]) ec++;
    end
    chk({rq, " byte plane mismatches"}, e8, 0);
    chk({rq, " R5 deep plane mismatches"}, e32, 0);
    chk({rq, " R6 control plane mismatches"}, ec, 0);
  endtask

  task automatic run_op(string rq, int dst, logic [23:0] src, int len, logic [31:0] col,
                        bit dp, bit raw);
    int s8, s32, sc, sb;
    @(negedge clk);
    depth24 = dp;
    s8 = c8; s32 = c32; sc = cc; sb = cb;
    bus_wr(24'h000000, col, 4'hF);
    bus_wr(cmd_addr(dst, raw), cmd_data(src, len), 4'hF);
    wait_idle();
    ref_apply(dst, src, len, col, dp, raw);
    cmp_planes(rq);
    chk("R2 byte writes", c8 - s8, len);
    chk("R8 busy cycles", cb - sb, len + 1);
    chk("R5 deep writes", c32 - s32, dp ? len : 0);
    chk("R6 control writes", cc - sc, (dp && raw) ? len : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int s8, sb;
    void'($urandom(32'd2718));
    for (int i = 0; i < MD; i++) begin r8[i] = i8(i); r32[i] = i32(i); rc[i] = ic(i); end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy in reset", busy, 0);
    chk("R10 plane requests in reset", {p8_rd, p8_wr, p32_rd, p32_wr, pc_rd, pc_wr}, 0);
    @(negedge clk); do_init = 1'b0; rst_ni = 1'b1;
    @(negedge clk);

    // R7 read returns zero without wait
    req = 1'b1; we = 1'b0; addr = cmd_addr(16, 1'b0); be = 4'hF; #1;
    chk("R7 read data", rdata, 0);
    chk("R7 read wait", wait_o, 0);
    @(negedge clk); req = 1'b0;

    // R1 holding write alone starts nothing
    s8 = c8; sb = cb;
    bus_wr(24'h000010, 32'h00AB_CDEF, 4'hF);
    repeat (4) @(negedge clk);
    chk("R1 no busy", cb - sb, 0);
    chk("R1 no writes", c8 - s8, 0);

    // R7 partial-width command ignored
    s8 = c8; sb = cb;
    bus_wr(cmd_addr(40, 1'b0), cmd_data(FILL, 4), 4'h7);
    repeat (4) @(negedge clk);
    chk("R7 partial no busy", cb - sb, 0);
    chk("R7 partial no writes", c8 - s8, 0);
    cmp_planes("R7");

    // R3 R5 minimum fill, depth off
    run_op("R3 fill len1", 50, FILL, 1, 32'h1122_3344, 1'b0, 1'b0);
    // R3 R5 max fill, deep, not raw
    run_op("R3 fill len32", 100, FILL, 32, 32'hDEAD_BEEF, 1'b1, 1'b0);
    // R6 raw fill
    run_op("R6 raw fill", 300, FILL, 7, 32'h0F0E_0D0C, 1'b1, 1'b1);
    // R4 copy, deep raw
    run_op("R4 copy", 500, 24'd900, 20, 32'h0, 1'b1, 1'b1);
    // R4 copy, byte only
    run_op("R4 copy byte", 1200, 24'd1500, 32, 32'h0, 1'b0, 1'b1);
    // R9 forward overlap replicates
    run_op("R9 overlap +1", 2001, 24'd2000, 12, 32'h0, 1'b1, 1'b1);
    chk("R9 replicated", {24'h0, m8[2012]}, {24'h0, m8[2000]});
    // R9 backward overlap shifts down
    run_op("R9 overlap -1", 2199, 24'd2200, 16, 32'h0, 1'b1, 1'b0);
    run_op("R9 overlap +2", 2402, 24'd2400, 20, 32'h0, 1'b1, 1'b1);

    // R8 holding write during a run, then a stalled command
    @(negedge clk); depth24 = 1'b1;
    bus_wr(24'h0, 32'h00A1_A2A3, 4'hF);
    bus_wr(cmd_addr(2600, 1'b0), cmd_data(FILL, 32), 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 24'h0; wdata = 32'h00B1_B2B3; be = 4'hF; #1;
    chk("R8 latch no wait", wait_o, 0);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    req = 1'b1; addr = cmd_addr(2700, 1'b0); wdata = cmd_data(FILL, 5); #1;
    chk("R8 command waits", wait_o, 1);
    while (wait_o) begin @(negedge clk); #1; end
    @(negedge clk); req = 1'b0; we = 1'b0;
    wait_idle();
    ref_apply(2600, FILL, 32, 32'h00A1_A2A3, 1'b1, 1'b0);
    ref_apply(2700, FILL, 5, 32'h00B1_B2B3, 1'b1, 1'b0);
    cmp_planes("R8 stalled pair");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int dst, len;
      logic [23:0] src;
      bit dp, raw, isfill;
      dst    = int'($urandom_range(0, 3900));
      len    = int'($urandom_range(1, 32));
      isfill = ($urandom_range(0, 3) == 0);
      src    = isfill ? FILL : 24'($urandom_range(0, 3900));
      dp     = 1'($urandom);
      raw    = 1'($urandom);
      run_op(isfill ? "R3 random fill" : "R4 random copy", dst, src, len, $urandom, dp, raw);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule